// File: doc/BRIEF.md
# Fuse-Lockable Wiper Register with Two-Wire Slave

This block is the digital control side of a 64-step digital potentiometer. A host on a two-wire serial bus, with a clock line of up to 400 kHz and an open-drain data line, sets and reads back a 6-bit tap code. The code drives the resistor ladder through `wiper_o`. The host can change the code as often as it needs while it tunes a circuit.

When the final code is known, the host sets the lock bit in a write frame. The data byte of that frame becomes the permanent setting. The block then raises `fuse_prog_o` for a fixed number of system clocks, which stands in for the fuse burn. At the end of that window it samples `fuse_sense_i` and records the result in a two-bit status field. Every later read returns that status next to the code. In this model the fuses are sticky flops that only `rst_ni` clears, which behaves like a blank part at power-up.

Both bus lines are resynchronised to the system clock through two flops and oversampled. At 125 MHz, a START or STOP is seen within three clocks. That is far inside the 0.6 µs START hold and the 1.3 µs bus-free time the bus guarantees. The `addr_sel_i` pin supplies the least significant address bit, so two of these blocks can share one bus.

Top module: `potd_otp_top`

## Requirements
- R1: After reset, `wiper_o` is 0x20, the status field is 00, `fuse_prog_o` is low and `sda_oe_o` is low.
- R2: The slave address is `{BASE_ADDR[6:1], addr_sel_i}`. On a match, the slave pulls SDA low during the ninth clock of the address byte.
- R3: A different address gets no acknowledge, and the slave drives nothing until the next START. A write frame sent to another address leaves `wiper_o` unchanged.
- R4: A write frame is the address byte with R/W=0, an instruction byte, then a data byte, each acknowledged. Bits [5:0] of the data byte load the wiper and bits [7:6] are ignored. Before a lock, any number of writes is accepted.
- R5: A read frame is the address byte with R/W=1 followed by one byte sent MSB first. That byte is `{status[1:0], wiper[5:0]}`.
- R6: Instruction bit 7 is the lock bit. A write frame with this bit set loads the data code, freezes it, and holds `fuse_prog_o` high for exactly BURN_CYCLES clocks, about 400 ms at the system clock rate.
- R7: Once a lock has been accepted, no later write frame changes `wiper_o`.
- R8: A lock frame received during a burn or after it is still acknowledged. It neither extends nor restarts the burn and produces no second `fuse_prog_o` pulse.
- R9: The status field reads 00 until the burn ends. It then becomes 11 if `fuse_sense_i` is high in the last burn clock and 10 otherwise. The code 01 never occurs.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP in the middle of a data byte discards that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the modelled fuses |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| addr_sel_i | input | 1 | Address select pin, becomes address bit 0 |
| fuse_sense_i | input | 1 | Fuse read-back sense, sampled at the end of the burn |
| wiper_o | output | 6 | Wiper tap code to the resistor ladder |
| fuse_prog_o | output | 1 | Fuse programming strobe |

## Verification
A wrong byte phase or bit count inside the slave shows up on the bus within one frame. It appears as a missing or misplaced acknowledge, or as a read byte shifted by one position, and the next read reports it through the scoreboard. A lost or corrupted freeze flag becomes visible at the next write frame after a lock, because `wiper_o` then moves. An off-by-one in the burn counter shows up as soon as the strobe falls, as a pulse length different from BURN_CYCLES. A mis-sampled fuse sense shows up in the status bits of the first read after the burn.

// File: rtl/potd_pkg.sv
package potd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_IGNORE
  } slv_state_e;

  localparam logic [1:0] STAT_BLANK = 2'b00;
  localparam logic [1:0] STAT_FAIL  = 2'b10;
  localparam logic [1:0] STAT_GOOD  = 2'b11;
endpackage

// File: rtl/potd_line_sync.sv
module potd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;   // idle bus is high
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/potd_i2c_slave.sv
module potd_i2c_slave
  import potd_pkg::*;
#(
  parameter int WIPER_W  = 6,
  parameter int LOCK_BIT = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [6:0]         dev_addr_i,
  input  logic [7:0]         tx_byte_i,
  output logic               sda_oe_o,
  output logic               wr_valid_o,
  output logic               wr_lock_o,
  output logic [WIPER_W-1:0] wr_data_o
);
  slv_state_e state_q;
  logic       scl_q, sda_q;
  logic [2:0] bit_cnt_q;
  logic       full_q;
  logic [7:0] shift_q, tx_q;
  logic [1:0] byte_idx_q;
  logic       rw_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      bit_cnt_q  <= '0;
      full_q     <= 1'b0;
      shift_q    <= '0;
      tx_q       <= '0;
      byte_idx_q <= '0;
      rw_q       <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_lock_o  <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      wr_valid_o <= 1'b0;
      if (start_det) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        full_q     <= 1'b0;
        byte_idx_q <= '0;
        sda_oe_o   <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        full_q   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              shift_q   <= {shift_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (bit_cnt_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
              full_q    <= 1'b0;
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shift_q[7:1] == dev_addr_i) begin
                  rw_q     <= shift_q[0];
                  sda_oe_o <= 1'b1;
                  state_q  <= ST_ACK;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (byte_idx_q == 2'd0) begin
                wr_lock_o  <= shift_q[LOCK_BIT];
                byte_idx_q <= 2'd1;
                sda_oe_o   <= 1'b1;
                state_q    <= ST_ACK;
              end else if (byte_idx_q == 2'd1) begin
                wr_data_o  <= shift_q[WIPER_W-1:0];
                wr_valid_o <= 1'b1;
                byte_idx_q <= 2'd2;
                sda_oe_o   <= 1'b1;
                state_q    <= ST_ACK;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                tx_q     <= tx_byte_i;
                sda_oe_o <= ~tx_byte_i[7];
                state_q  <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (bit_cnt_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall) begin
              if (full_q) begin
                full_q   <= 1'b0;
                sda_oe_o <= 1'b0;
                state_q  <= ST_TXACK;
              end else begin
                tx_q     <= {tx_q[6:0], 1'b0};
                sda_oe_o <= ~tx_q[6];
              end
            end
          end
          ST_TXACK: if (scl_rise) state_q <= ST_IGNORE;
          default: ;
        endcase
      end
    end
  end

  // R2: the slave drives SDA only while acknowledging or sending
  a_r2_drive_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_q == ST_ACK || state_q == ST_TX));
  // R10: a STOP always releases the line
  a_r10_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
  // R3: a non-matching address leaves the line undriven
  a_r3_ignore_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_oe_o);
endmodule

// File: rtl/potd_otp_ctrl.sv
module potd_otp_ctrl
  import potd_pkg::*;
#(
  parameter int WIPER_W     = 6,
  parameter int BURN_CYCLES = 50_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic               wr_lock_i,
  input  logic [WIPER_W-1:0] wr_data_i,
  input  logic               fuse_sense_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic [1:0]         status_o,
  output logic               fuse_prog_o
);
  localparam int                  CW       = $clog2(BURN_CYCLES + 1);
  localparam logic [CW-1:0]       LAST_CNT = CW'(BURN_CYCLES - 1);
  localparam logic [WIPER_W-1:0]  MIDSCALE = WIPER_W'(1 << (WIPER_W - 1));

  logic          frozen_q, burning_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_o   <= MIDSCALE;
      frozen_q  <= 1'b0;
      burning_q <= 1'b0;
      cnt_q     <= '0;
      status_o  <= STAT_BLANK;
    end else begin
      if (wr_valid_i && !frozen_q) begin
        wiper_o <= wr_data_i;
        if (wr_lock_i) begin
          frozen_q  <= 1'b1;
          burning_q <= 1'b1;
          cnt_q     <= '0;
        end
      end
      if (burning_q) begin
        if (cnt_q == LAST_CNT) begin
          burning_q <= 1'b0;
          status_o  <= fuse_sense_i ? STAT_GOOD : STAT_FAIL;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fuse_prog_o = burning_q;

  // R7: code cannot move once frozen
  a_r7_wiper_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |=> $stable(wiper_o));
  // R6: burn counter stays within its window
  a_r6_burn_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burning_q |-> (cnt_q <= LAST_CNT));
  // R8: strobe only after an accepted lock
  a_r8_prog_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_prog_o |-> frozen_q);
  // R9: 01 is never reported, and a finished burn reports a result
  a_r9_status_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b01);
  a_r9_status_after_burn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(burning_q) |-> status_o[1]);
  a_r9_blank_while_burning: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burning_q |-> (status_o == STAT_BLANK));
endmodule

// File: rtl/potd_otp_top.sv
module potd_otp_top
  import potd_pkg::*;
#(
  parameter int         WIPER_W     = 6,
  parameter int         BURN_CYCLES = 50_000_000,
  parameter logic [6:0] BASE_ADDR   = 7'h36,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               addr_sel_i,
  input  logic               fuse_sense_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               fuse_prog_o
);
  logic               scl_s, sda_s;
  logic               wr_valid, wr_lock;
  logic [WIPER_W-1:0] wr_data;
  logic [1:0]         status;
  logic [6:0]         dev_addr;
  logic [7:0]         rd_byte;

  assign dev_addr = {BASE_ADDR[6:1], addr_sel_i};
  assign rd_byte  = 8'({status, wiper_o});

  potd_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  potd_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  potd_i2c_slave #(.WIPER_W(WIPER_W)) u_slave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .dev_addr_i (dev_addr),
    .tx_byte_i  (rd_byte),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid),
    .wr_lock_o  (wr_lock),
    .wr_data_o  (wr_data)
  );

  potd_otp_ctrl #(.WIPER_W(WIPER_W), .BURN_CYCLES(BURN_CYCLES)) u_otp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_valid_i   (wr_valid),
    .wr_lock_i    (wr_lock),
    .wr_data_i    (wr_data),
    .fuse_sense_i (fuse_sense_i),
    .wiper_o      (wiper_o),
    .status_o     (status),
    .fuse_prog_o  (fuse_prog_o)
  );

  // R1: quiet outputs while held in reset
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!sda_oe_o && !fuse_prog_o);
    end
  end
endmodule

// File: tb/potd_otp_top_tb_top.sv
module potd_otp_top_tb_top;
  localparam int         BURN = 4000;
  localparam logic [6:0] BASE = 7'h36;
  localparam int         Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b0, fuse_sense = 1'b0;
  logic sda_oe, fuse_prog;
  logic [5:0] wiper;
  logic bus_sda;

  assign bus_sda = m_sda & ~sda_oe;

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  potd_otp_top #(.BURN_CYCLES(BURN), .BASE_ADDR(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .fuse_sense_i(fuse_sense),
    .wiper_o(wiper), .fuse_prog_o(fuse_prog));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int prog_cnt = 0, prog_pulses = 0;
  logic prog_d = 1'b0;

  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];

  always @(negedge clk) begin
    if (fuse_prog) prog_cnt++;
    if (fuse_prog && !prog_d) prog_pulses++;
    prog_d <= fuse_prog;
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0 && act_q.size() > 0) begin
        logic [7:0] e, a;
        string t;
        e = exp_q.pop_front(); a = act_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s read byte act=%02h exp=%02h", t, a, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; half();
    m_sda = 1'b0; half();
    m_scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; half();
    m_scl = 1'b1; half();
    m_sda = 1'b1; half();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; half();
      m_scl = 1'b1; half();
      m_scl = 1'b0; half();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; half();
    m_scl = 1'b1; half();
    ack = (bus_sda == 1'b0);
    m_scl = 1'b0; half();
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] ins,
                          input logic [7:0] d, output bit ok);
    bit k0, k1, k2;
    bus_start();
    send_byte({a, 1'b0}, k0);
    k1 = 1'b0; k2 = 1'b0;
    if (k0) begin
      send_byte(ins, k1);
      send_byte(d, k2);
    end
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string tag);
    bit k;
    logic [7:0] b;
    bus_start();
    send_byte({a, 1'b1}, k);
    chk(k, {tag, " read address ack"}, k, 1);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      half();
      m_scl = 1'b1; half();
      b = {b[6:0], bus_sda};
      m_scl = 1'b0;
    end
    half();
    m_scl = 1'b1; half();   // master NACK
    m_scl = 1'b0; half();
    bus_stop();
    exp_q.push_back(exp); act_q.push_back(b); tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int saved_cnt;
    do_reset();
    // R1 reset state
    chk(wiper == 6'h20, "R1 wiper after reset", wiper, 6'h20);
    chk(!fuse_prog, "R1 strobe after reset", fuse_prog, 0);
    chk(!sda_oe, "R1 sda released", sda_oe, 0);
    do_read(BASE, 8'h20, "R1 R5 reset read");

    // R4 unlimited writes, R5 read-back
    do_write(BASE, 8'h00, 8'h05, ok);
    chk(ok, "R4 write acked", ok, 1);
    chk(wiper == 6'h05, "R4 wiper 05", wiper, 6'h05);
    do_read(BASE, 8'h05, "R5 read 05");
    do_write(BASE, 8'h00, 8'h3F, ok);
    chk(wiper == 6'h3F, "R4 full scale", wiper, 6'h3F);
    do_write(BASE, 8'h00, 8'hC0, ok);
    chk(wiper == 6'h00, "R4 upper data bits ignored", wiper, 6'h00);
    do_read(BASE, 8'h00, "R5 read zero scale");

    // R3 wrong address
    do_write(BASE | 7'h01, 8'h00, 8'h11, ok);
    chk(!ok, "R3 foreign address nack", ok, 0);
    chk(wiper == 6'h00, "R3 wiper untouched", wiper, 6'h00);

    // R2 address select pin
    addr_sel = 1'b1;
    do_write(BASE | 7'h01, 8'h00, 8'h11, ok);
    chk(ok, "R2 alternate address acked", ok, 1);
    chk(wiper == 6'h11, "R2 wiper via alternate address", wiper, 6'h11);
    do_write(BASE & 7'h7E, 8'h00, 8'h22, ok);
    chk(!ok, "R3 old address now foreign", ok, 0);

    // R10 STOP mid data byte discards it
    begin
      bit k;
      bus_start();
      send_byte({BASE | 7'h01, 1'b0}, k);
      send_byte(8'h00, k);
      send_bits(8'h2B, 4);
      bus_stop();
    end
    chk(wiper == 6'h11, "R10 aborted byte discarded", wiper, 6'h11);
    do_read(BASE | 7'h01, 8'h11, "R10 read after abort");
    addr_sel = 1'b0;

    // R6 lock with failing sense
    fuse_sense = 1'b0;
    prog_cnt = 0; prog_pulses = 0;
    do_write(BASE, 8'h80, 8'h2A, ok);
    chk(ok, "R6 lock acked", ok, 1);
    chk(wiper == 6'h2A, "R6 lock loads code", wiper, 6'h2A);
    chk(fuse_prog, "R6 strobe during burn", fuse_prog, 1);
    do_read(BASE, 8'h2A, "R9 status blank during burn");
    do_write(BASE, 8'h80, 8'h15, ok);
    chk(ok, "R8 second lock acked", ok, 1);
    do_write(BASE, 8'h00, 8'h01, ok);
    chk(wiper == 6'h2A, "R7 write during burn ignored", wiper, 6'h2A);
    while (fuse_prog) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(prog_cnt == BURN, "R6 strobe length", prog_cnt, BURN);
    chk(prog_pulses == 1, "R8 single pulse", prog_pulses, 1);
    do_read(BASE, 8'hAA, "R9 failed burn status 10");
    do_write(BASE, 8'h00, 8'h07, ok);
    chk(wiper == 6'h2A, "R7 write after lock ignored", wiper, 6'h2A);
    saved_cnt = prog_cnt;
    do_write(BASE, 8'h80, 8'h07, ok);
    chk(ok, "R8 lock after burn acked", ok, 1);
    repeat (20) @(negedge clk);
    chk(prog_cnt == saved_cnt && !fuse_prog, "R8 no new burn", prog_cnt, saved_cnt);

    // second part: good sense
    do_reset();
    chk(wiper == 6'h20, "R1 wiper after second reset", wiper, 6'h20);
    fuse_sense = 1'b1;
    do_write(BASE, 8'h80, 8'h3F, ok);
    while (fuse_prog) @(negedge clk);
    repeat (4) @(negedge clk);
    do_read(BASE, 8'hFF, "R9 verified status 11");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && act_q.size() == 0, "R5 scoreboard drained",
        act_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule